// File: doc/BRIEF.md
# Lifting-Based 8-Point DCT-II Engine

The block computes an 8-point orthonormal Type-II DCT, or its exact inverse, on one vector of eight signed 32-bit coefficients at a time. The arithmetic uses only integer lifting steps, half-value butterflies, adds and subtracts. No general multiply-accumulate rotation is used. Because every step can be undone exactly in integer arithmetic, the inverse mode returns the vector that entered the forward mode, bit for bit. The reverse also holds: the forward transform of an inverse result gives back the coefficients. Samples are meant to arrive pre-scaled by 16 (four fractional bits).

The datapath has three parts. The first is a butterfly stage that pairs samples and keeps a rounded half of one member of each pair. The second is an even half: a 4-point asymmetric DCT that ends in an embedded 2-point DCT and an embedded 2-point Type-IV DST. The third is an odd half: a 4-point asymmetric Type-IV DST.

One vector moves per valid/ready transfer. A select bit travels with each vector and picks forward or inverse for that vector alone. The result is held in a single output register until the consumer accepts it.

Top module: `lxfm8_core`

## Requirements
- R1: The forward transform of the vector with all eight elements equal to 16 is 45 in element 0 and 0 elsewhere. For all elements equal to -16 it is -45 in element 0 and 0 elsewhere. Element k occupies bits [32k+31:32k] of a data bus.
- R2: For any input with every element in [-2^20, 2^20], the inverse of the forward result equals the input exactly. The forward of the inverse result also equals the input exactly.
- R3: Each lifting term is the floor of (b*C + 2^(S-1)) / 2^S, formed from a product at least 48 bits wide. Each half value is the operand divided by 2 with rounding toward zero.
- R4: The forward result equals the following sequence. Samples 0..7 are placed into slots s0,s4,s2,s6,s1,s5,s3,s7 in that order. The butterflies come first. Then the even half runs on (s0,s2,s4,s6), and the odd half on (s7,s5,s3,s1) with constants 7489/13, 11585/14, 19195/15, 6723/13, 8035/13, 6723/13, 8757/14, 6811/13, 8757/14. Output element k is slot sk.
- R5: In inverse mode (in_inverse = 1), input (45,0,...,0) yields all elements 16, and (-45,0,...,0) yields all elements -16.
- R6: An all-zero vector gives an all-zero result in either mode.
- R7: in_ready is high whenever out_valid is low or out_ready is high. A vector accepted at a clock edge appears on out_data with out_valid high after that same edge.
- R8: While out_valid is high and out_ready is low, out_data and out_valid hold and no new vector is taken.
- R9: While rst_n is low, out_valid is 0 and in_ready is 1.
- R10: The mode is taken per vector. Back-to-back vectors with different modes each get their own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Block can take a vector this cycle |
| in_inverse | input | 1 | 0 = forward transform, 1 = inverse transform |
| in_data | input | 256 | Eight signed coefficients, element k at bits [32k+31:32k] |
| out_valid | output | 1 | Result register holds a vector |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 256 | Eight signed results, same packing as in_data |

## Verification
The in-module properties watch the transfer rules on every cycle. These cover readiness under back-pressure, a result appearing after each accepted vector, the result holding during a stall, the register draining once taken, and zero mapping to zero. The numerical content cannot be expressed as a simple property. This covers the rounding of each lifting term, the slot ordering, exact reconstruction, and the per-vector mode choice. Only the bench's scenarios show it: known DC vectors in both directions, random vectors compared against an independent step model, and round trips in both orders.

// File: rtl/lxfm_pkg.sv
package lxfm_pkg;
  localparam int COEF_W = 32;
  localparam int PROD_W = 48;
  localparam int NPTS   = 8;
  localparam int LOG_N  = 3;
  localparam int HALF_N = NPTS / 2;
  localparam int VEC_W  = NPTS * COEF_W;

  typedef logic signed [COEF_W-1:0] coef_t;

  // Rounded dyadic lifting term: floor((b*c + 2^(s-1)) / 2^s).
  function automatic coef_t lift(coef_t b, int c, int s);
    logic signed [PROD_W-1:0] bx, cx, rnd, acc;
    bx  = PROD_W'(b);
    cx  = PROD_W'(c);
    rnd = PROD_W'(1) <<< (s - 1);
    acc = (bx * cx + rnd) >>> s;
    return acc[COEF_W-1:0];
  endfunction

  // Half value rounded toward zero: add the sign bit, then shift.
  function automatic coef_t half_tz(coef_t v);
    coef_t t;
    t = v + coef_t'({{(COEF_W-1){1'b0}}, v[COEF_W-1]});
    return t >>> 1;
  endfunction

  // Slot index of sample k (bit reversal over LOG_N bits).
  function automatic int slot_of(int k);
    int r;
    r = 0;
    for (int b = 0; b < LOG_N; b++) r = r | (((k >> b) & 1) << (LOG_N - 1 - b));
    return r;
  endfunction
endpackage

// File: rtl/lxfm_bfly.sv
module lxfm_bfly
  import lxfm_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  coef_t d_in  [NPTS],
  output coef_t d_out [NPTS]
);
  for (genvar p = 0; p < HALF_N; p++) begin : g_pair
    localparam int LO = p;
    localparam int HI = NPTS - 1 - p;
    coef_t mid;
    if (p % 2 == 0) begin : g_diff
      if (!INVERSE) begin : g_f
        assign mid        = d_in[LO] - d_in[HI];
        assign d_out[HI]  = mid;
        assign d_out[LO]  = d_in[LO] - half_tz(mid);
      end else begin : g_i
        assign mid        = d_in[LO] + half_tz(d_in[HI]);
        assign d_out[LO]  = mid;
        assign d_out[HI]  = mid - d_in[HI];
      end
    end else begin : g_sum
      if (!INVERSE) begin : g_f
        assign mid        = d_in[HI] + d_in[LO];
        assign d_out[HI]  = mid;
        assign d_out[LO]  = half_tz(mid) - d_in[LO];
      end else begin : g_i
        assign mid        = half_tz(d_in[HI]) - d_in[LO];
        assign d_out[LO]  = mid;
        assign d_out[HI]  = d_in[HI] - mid;
      end
    end
  end
endmodule

// File: rtl/lxfm_even.sv
// Even half: 4-point asymmetric DCT with embedded 2-point DCT and DST-IV.
// Port order: [0]=q0 [1]=q1 [2]=q2 [3]=q3.
module lxfm_even
  import lxfm_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  coef_t d_in  [HALF_N],
  output coef_t d_out [HALF_N]
);
  coef_t q0, q1, q2, q3;

  if (!INVERSE) begin : g_fwd
    always_comb begin
      q0 = d_in[0]; q1 = d_in[1]; q2 = d_in[2]; q3 = d_in[3];
      q0 = q0 + half_tz(q3);
      q3 = q0 - q3;
      q1 = half_tz(q2) - q1;
      q2 = q1 - q2;
      q0 = q0 - lift(q2, 13573, 15);
      q2 = q2 + lift(q0, 5793, 13);
      q0 = q0 - lift(q2, 3393, 13);
      q3 = q3 - lift(q1, 10947, 14);
      q1 = q1 + lift(q3, 473, 9);
      q3 = q3 - lift(q1, 10947, 14);
    end
  end else begin : g_inv
    always_comb begin
      q0 = d_in[0]; q1 = d_in[1]; q2 = d_in[2]; q3 = d_in[3];
      q3 = q3 + lift(q1, 10947, 14);
      q1 = q1 - lift(q3, 473, 9);
      q3 = q3 + lift(q1, 10947, 14);
      q0 = q0 + lift(q2, 3393, 13);
      q2 = q2 - lift(q0, 5793, 13);
      q0 = q0 + lift(q2, 13573, 15);
      q2 = q1 - q2;
      q1 = half_tz(q2) - q1;
      q3 = q0 - q3;
      q0 = q0 - half_tz(q3);
    end
  end

  assign d_out[0] = q0;
  assign d_out[1] = q1;
  assign d_out[2] = q2;
  assign d_out[3] = q3;
endmodule

// File: rtl/lxfm_odd.sv
// Odd half: 4-point asymmetric Type-IV DST.
// Port order: [0]=t0 [1]=t1 [2]=t2 [3]=t3.
module lxfm_odd
  import lxfm_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  coef_t d_in  [HALF_N],
  output coef_t d_out [HALF_N]
);
  coef_t t0, t1, t2, t3;

  if (!INVERSE) begin : g_fwd
    always_comb begin
      t0 = d_in[0]; t1 = d_in[1]; t2 = d_in[2]; t3 = d_in[3];
      t2 = t2 - lift(t1, 7489, 13);
      t1 = t1 + lift(t2, 11585, 14);
      t2 = t2 + lift(t1, 19195, 15);
      t3 = t3 + half_tz(t2);
      t2 = t2 - t3;
      t1 = half_tz(t0) - t1;
      t0 = t0 - t1;
      t3 = t3 + lift(t0, 6723, 13);
      t0 = t0 - lift(t3, 8035, 13);
      t3 = t3 + lift(t0, 6723, 13);
      t2 = t2 + lift(t1, 8757, 14);
      t1 = t1 - lift(t2, 6811, 13);
      t2 = t2 + lift(t1, 8757, 14);
    end
  end else begin : g_inv
    always_comb begin
      t0 = d_in[0]; t1 = d_in[1]; t2 = d_in[2]; t3 = d_in[3];
      t2 = t2 - lift(t1, 8757, 14);
      t1 = t1 + lift(t2, 6811, 13);
      t2 = t2 - lift(t1, 8757, 14);
      t3 = t3 - lift(t0, 6723, 13);
      t0 = t0 + lift(t3, 8035, 13);
      t3 = t3 - lift(t0, 6723, 13);
      t0 = t0 + t1;
      t1 = half_tz(t0) - t1;
      t2 = t2 + t3;
      t3 = t3 - half_tz(t2);
      t2 = t2 - lift(t1, 19195, 15);
      t1 = t1 - lift(t2, 11585, 14);
      t2 = t2 + lift(t1, 7489, 13);
    end
  end

  assign d_out[0] = t0;
  assign d_out[1] = t1;
  assign d_out[2] = t2;
  assign d_out[3] = t3;
endmodule

// File: rtl/lxfm8_core.sv
module lxfm8_core
  import lxfm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_inverse,
  input  logic [VEC_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  coef_t in_c  [NPTS];
  coef_t f_s   [NPTS];
  coef_t f_b   [NPTS];
  coef_t f_ei  [HALF_N];
  coef_t f_eo  [HALF_N];
  coef_t f_oi  [HALF_N];
  coef_t f_oo  [HALF_N];
  coef_t f_y   [NPTS];
  coef_t i_ei  [HALF_N];
  coef_t i_eo  [HALF_N];
  coef_t i_oi  [HALF_N];
  coef_t i_oo  [HALF_N];
  coef_t i_m   [NPTS];
  coef_t i_b   [NPTS];
  logic [VEC_W-1:0] nxt_data;

  // Handshake events, named for the properties below.
  logic in_fire, out_fire, out_stall;
  assign in_ready  = !out_valid || out_ready;
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign out_stall = out_valid && !out_ready;

  for (genvar k = 0; k < NPTS; k++) begin : g_lane
    assign in_c[k] = in_data[k*COEF_W +: COEF_W];
    assign f_s[k]  = in_c[slot_of(k)];
    assign nxt_data[k*COEF_W +: COEF_W] = in_inverse ? i_b[slot_of(k)] : f_y[k];
  end

  // Even slots go to the even half, odd slots (descending) to the odd half.
  for (genvar j = 0; j < HALF_N; j++) begin : g_split
    assign f_ei[j]              = f_b[2*j];
    assign f_oi[j]              = f_b[NPTS-1-2*j];
    assign f_y[2*j]             = f_eo[j];
    assign f_y[NPTS-1-2*j]      = f_oo[j];
    assign i_ei[j]              = in_c[2*j];
    assign i_oi[j]              = in_c[NPTS-1-2*j];
    assign i_m[2*j]             = i_eo[j];
    assign i_m[NPTS-1-2*j]      = i_oo[j];
  end

  lxfm_bfly #(.INVERSE(1'b0)) u_fbfly (.d_in(f_s),  .d_out(f_b));
  lxfm_even #(.INVERSE(1'b0)) u_feven (.d_in(f_ei), .d_out(f_eo));
  lxfm_odd  #(.INVERSE(1'b0)) u_fodd  (.d_in(f_oi), .d_out(f_oo));

  lxfm_even #(.INVERSE(1'b1)) u_ieven (.d_in(i_ei), .d_out(i_eo));
  lxfm_odd  #(.INVERSE(1'b1)) u_iodd  (.d_in(i_oi), .d_out(i_oo));
  lxfm_bfly #(.INVERSE(1'b1)) u_ibfly (.d_in(i_m),  .d_out(i_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_data  <= nxt_data;
    end else if (out_fire) begin
      out_valid <= 1'b0;
    end
  end

  // R7: back-pressure blocks new input
  p_block_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |-> !in_ready);
  // R7: an accepted vector is presented after the edge
  p_accept_gives_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);
  // R8: a stalled result holds
  p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |=> out_valid && $stable(out_data));
  // R7: a taken result with nothing new behind it drains
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !in_valid) |=> !out_valid);
  // R6: zero maps to zero in either mode
  p_zero_maps_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_data == '0) |=> out_data == '0);
endmodule

// File: tb/lxfm8_core_test.sv
`timescale 1ns/1ps
module lxfm8_core_test;
  import lxfm_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_inverse = 1'b0;
  logic [VEC_W-1:0] in_data = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [VEC_W-1:0] out_data;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  lxfm8_core uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_inverse(in_inverse), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  // Table rows: {inverse, input (element 7 .. element 0), expected}
  localparam int ROWS = 6;
  localparam logic [2*VEC_W:0] TAB [ROWS] = '{
    {1'b0, {8{32'sd0}},           {8{32'sd0}}},
    {1'b0, {8{32'sd16}},          {7{32'sd0}}, 32'sd45},
    {1'b0, {8{-32'sd16}},         {7{32'sd0}}, -32'sd45},
    {1'b1, {7{32'sd0}}, 32'sd45,  {8{32'sd16}}},
    {1'b1, {7{32'sd0}}, -32'sd45, {8{-32'sd16}}},
    {1'b1, {8{32'sd0}},           {8{32'sd0}}}
  };
  localparam string TAB_REQ [ROWS] = '{"R6", "R1", "R1", "R5", "R5", "R6"};

  // ---- independent step model (floor division, conditional halving) ----
  function automatic int mhalf(int v);
    return (v < 0) ? -((-v) / 2) : v / 2;
  endfunction

  function automatic int mlift(int b, int c, int sh);
    longint n, d, q;
    n = longint'(b) * longint'(c) + (longint'(1) << (sh - 1));
    d = longint'(1) << sh;
    q = n / d;
    if (n < 0 && q * d != n) q = q - 1;
    return int'(q);
  endfunction

  function automatic logic [VEC_W-1:0] model_fwd(logic [VEC_W-1:0] x);
    int s0, s1, s2, s3, s4, s5, s6, s7;
    s0 = int'(x[0*32 +: 32]); s4 = int'(x[1*32 +: 32]);
    s2 = int'(x[2*32 +: 32]); s6 = int'(x[3*32 +: 32]);
    s1 = int'(x[4*32 +: 32]); s5 = int'(x[5*32 +: 32]);
    s3 = int'(x[6*32 +: 32]); s7 = int'(x[7*32 +: 32]);
    s7 = s0 - s7; s0 -= mhalf(s7);
    s6 += s1;     s1 = mhalf(s6) - s1;
    s5 = s2 - s5; s2 -= mhalf(s5);
    s4 += s3;     s3 = mhalf(s4) - s3;
    s0 += mhalf(s6); s6 = s0 - s6; s2 = mhalf(s4) - s2; s4 = s2 - s4;
    s0 -= mlift(s4, 13573, 15); s4 += mlift(s0, 5793, 13); s0 -= mlift(s4, 3393, 13);
    s6 -= mlift(s2, 10947, 14); s2 += mlift(s6, 473, 9);   s6 -= mlift(s2, 10947, 14);
    s3 -= mlift(s5, 7489, 13);  s5 += mlift(s3, 11585, 14); s3 += mlift(s5, 19195, 15);
    s1 += mhalf(s3); s3 -= s1; s5 = mhalf(s7) - s5; s7 -= s5;
    s1 += mlift(s7, 6723, 13);  s7 -= mlift(s1, 8035, 13);  s1 += mlift(s7, 6723, 13);
    s3 += mlift(s5, 8757, 14);  s5 -= mlift(s3, 6811, 13);  s3 += mlift(s5, 8757, 14);
    return {s7, s6, s5, s4, s3, s2, s1, s0};
  endfunction

  function automatic logic [VEC_W-1:0] rand_vec();
    logic [VEC_W-1:0] v;
    for (int k = 0; k < NPTS; k++)
      v[k*32 +: 32] = $unsigned(int'($urandom_range(0, 2097152)) - 1048576);
    return v;
  endfunction

  task automatic check_bit(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic check_vec(string req, logic [VEC_W-1:0] got, logic [VEC_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      for (int k = 0; k < NPTS; k++)
        if (got[k*32 +: 32] !== exp[k*32 +: 32]) begin
          $display("FAIL %s element %0d: got %0d expected %0d", req, k,
                   $signed(got[k*32 +: 32]), $signed(exp[k*32 +: 32]));
          break;
        end
    end
  endtask

  // One transfer with the consumer ready; result sampled at the next falling edge.
  task automatic xfer(input logic inv, input logic [VEC_W-1:0] d, output logic [VEC_W-1:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_inverse = inv; in_data = d; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    res = out_data;
    check_bit("R7", "out_valid after accept", out_valid, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [VEC_W-1:0] r, r2, a, b, c;
    // R9: reset state
    repeat (2) @(negedge clk);
    check_bit("R9", "out_valid in reset", out_valid, 1'b0);
    check_bit("R9", "in_ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;

    // Table of directed vectors (R1, R5, R6)
    for (int i = 0; i < ROWS; i++) begin
      xfer(TAB[i][2*VEC_W], TAB[i][2*VEC_W-1 -: VEC_W], r);
      check_vec(TAB_REQ[i], r, TAB[i][VEC_W-1:0]);
    end

    // R3/R4 against step model, R2 round trips in both orders
    for (int n = 0; n < 40; n++) begin
      a = rand_vec();
      xfer(1'b0, a, r);
      check_vec("R4", r, model_fwd(a));
      xfer(1'b1, r, r2);
      check_vec("R2", r2, a);
      b = rand_vec();
      xfer(1'b1, b, r);
      xfer(1'b0, r, r2);
      check_vec("R2", r2, b);
    end

    // R3: impulses exercise rounding of single lifts at small magnitude
    for (int k = 0; k < NPTS; k++) begin
      a = '0; a[k*32 +: 32] = (k % 2 == 0) ? 32'sd16 : -32'sd16;
      xfer(1'b0, a, r);
      check_vec("R3", r, model_fwd(a));
    end

    // R10: back-to-back vectors with alternating modes
    a = rand_vec(); c = rand_vec(); b = model_fwd(c);
    @(negedge clk);
    in_valid = 1'b1; in_inverse = 1'b0; in_data = a; out_ready = 1'b1;
    @(negedge clk);
    check_vec("R10", out_data, model_fwd(a));
    in_inverse = 1'b1; in_data = b;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec("R10", out_data, c);

    // R8: stall holds the result and blocks input; release takes the next vector
    a = rand_vec(); b = rand_vec();
    @(negedge clk);
    in_valid = 1'b1; in_inverse = 1'b0; in_data = a; out_ready = 1'b0;
    @(negedge clk);
    in_data = b;
    check_bit("R7", "in_ready during stall", in_ready, 1'b0);
    repeat (3) @(negedge clk);
    check_vec("R8", out_data, model_fwd(a));
    check_bit("R8", "out_valid during stall", out_valid, 1'b1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_vec("R8", out_data, model_fwd(b));
    @(negedge clk);
    check_bit("R7", "drain after take", out_valid, 1'b0);

    // R9: reset while holding a result
    @(negedge clk);
    in_valid = 1'b1; in_data = a; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check_bit("R9", "out_valid after mid-run reset", out_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; out_ready = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule